// File: doc/BRIEF.md
# Pulse-Transformer PWM Gate Encoder

This block sits on the isolated side of a forward converter. It produces a fixed-frequency PWM on-time and folds that on-time into one pair of complementary drive lines for a pulse transformer. Each switching period is split evenly. During the first half the positive line is high and the negative line is low. During the second half the levels are swapped. The transformer therefore sees a steady 50% waveform that stays in volt-second balance and also carries bias power to the far side.

Turn-on is the start of the positive half. When a peak-current trip cuts the on-time short, the block pulls both lines low for a short notch of about 150 ns, so that the differential across the transformer is zero. When no trip arrives, the PWM is forced off at the maximum-duty point. In 50% mode that point is the half-cycle edge. In 75% mode it falls at three quarters of the period, and an early end after mid-period is marked by a notch inside the negative half. A trip seen in the last clock of a period makes the next period a 0% duty period. That period has no on-time and starts with a notch, but it keeps its full two-half structure.

Top module: `pte_gate_encoder`

## Requirements
- R1: While `rst` is high, and in the clock cycle after it is released, `pt_pos`, `pt_neg` and `pwm_mon` are all low. The first rising edge with `rst` low begins period count 0.
- R2: A period lasts PERIOD_CLKS clocks, with counts 0 to PERIOD_CLKS-1. Outside notches, `pt_pos` is high and `pt_neg` is low for counts below PERIOD_CLKS/2, the levels are reversed for the remaining counts, and the two lines are never high together.
- R3: `pwm_mon` is high from count 0 until the limit count L and is low from L on. L = PERIOD_CLKS/2 when `dmax_sel` is 0 and L = 3*PERIOD_CLKS/4 when it is 1.
- R4: `ilim_trip` is sampled on each rising edge. A trip sampled at count k while `pwm_mon` is high, with k < L-1, makes `pwm_mon` low from count k+1. Any later trip in the same period has no effect on the outputs.
- R5: An honoured trip at count k drives both lines low for NOTCH = ceil(NOTCH_NS*CLK_MHZ/1000) clocks (19 by default), starting at count k+1. The notch is cut short at the end of the half-cycle it starts in, and that half-cycle's levels then resume.
- R6: When the on-time runs to L, including a trip sampled at count L-1, no notch is produced in that period.
- R7: A trip sampled at count PERIOD_CLKS-1 makes the next period 0% duty. In that period `pwm_mon` stays low throughout, the notch covers counts 0 to NOTCH-1, and the negative half follows normally.
- R8: In 75% mode, a trip honoured at a count k with k+1 >= PERIOD_CLKS/2 places the notch in the negative half, with both lines low, ending by the period end at the latest.
- R9: `dmax_sel` is sampled only on the edge that starts a period. Changing it during a period does not alter that period's limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ilim_trip | input | 1 | Peak-current trip strobe, sampled every clock |
| dmax_sel | input | 1 | Maximum-duty select: 0 = 50%, 1 = 75% |
| pt_pos | output | 1 | Positive pulse-transformer drive line |
| pt_neg | output | 1 | Negative pulse-transformer drive line |
| pwm_mon | output | 1 | PWM on-time, for observation |

## Verification
The hardest case to reach is a notch that crosses a boundary. This happens when a trip lands just before mid-period in 75% mode, so that the notch starts in, or runs into, the negative half. It also happens when a trip in the last clock of a period turns the following period into a 0% duty period. The stimulus sweeps a single-clock trip over every count of a period in both duty modes, together with a no-trip period, so every placement of the notch against both half edges is covered. Held trips then span a whole period, which chains 0% duty periods and checks that later trips are ignored. In every period the duty select is toggled mid-period, to show that it takes effect only at the next period start.

// File: rtl/pte_pkg.sv
package pte_pkg;

  // Notch length in clocks, rounded up so the notch is never shorter than asked.
  function automatic int unsigned notch_len(int unsigned clk_mhz, int unsigned notch_ns);
    return (clk_mhz * notch_ns + 999) / 1000;
  endfunction

  // Count at which the on-time is forced off: half or three quarters of the period.
  function automatic int unsigned max_on(int unsigned period, logic hi_mode);
    return hi_mode ? (period * 3) / 4 : period / 2;
  endfunction

endpackage

// File: rtl/pte_period_timer.sv
module pte_period_timer
  import pte_pkg::*;
#(
  parameter int unsigned PERIOD_CLKS = 64,
  parameter int unsigned CW          = $clog2(PERIOD_CLKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic dmax_sel,
  output logic live,
  output logic wrap,
  output logic half_edge,
  output logic in_pos,
  output logic on_win,
  output logic pre_last,
  output logic at_max_m1
);

  localparam logic [CW-1:0] LAST    = CW'(PERIOD_CLKS - 1);
  localparam logic [CW-1:0] HALF    = CW'(PERIOD_CLKS / 2);
  localparam logic [CW-1:0] HALF_M1 = CW'(PERIOD_CLKS / 2 - 1);
  localparam logic [CW-1:0] LIM50   = CW'(max_on(PERIOD_CLKS, 1'b0));
  localparam logic [CW-1:0] LIM75   = CW'(max_on(PERIOD_CLKS, 1'b1));

  logic [CW-1:0] cnt;
  logic          mode_q;
  logic [CW-1:0] lim;
  logic [CW-1:0] lim_m1;

  always_comb begin
    lim       = mode_q ? LIM75 : LIM50;
    lim_m1    = lim - CW'(1);
    wrap      = (cnt == LAST);
    half_edge = (cnt == HALF_M1);
    in_pos    = (cnt < HALF);
    on_win    = (cnt < lim);
    pre_last  = (cnt < lim_m1);
    at_max_m1 = (cnt == lim_m1);
  end

  // Reset parks the count on the last slot, so the first live edge opens count 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= LAST;
      live   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      live <= 1'b1;
      cnt  <= wrap ? '0 : cnt + CW'(1);
      if (wrap) mode_q <= dmax_sel;
    end
  end

endmodule

// File: rtl/pte_ontime_ctrl.sv
module pte_ontime_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic live,
  input  logic wrap,
  input  logic on_win,
  input  logic pre_last,
  output logic pwm,
  output logic take,
  output logic pre_end
);

  logic ended;

  always_comb begin
    // A trip on the final on-time count coincides with forced turn-off and is not taken.
    take    = trip && live && !ended && pre_last;
    // A trip on the last count of a period cancels the next period's on-time.
    pre_end = trip && wrap;
    pwm     = live && !ended && on_win;
  end

  always_ff @(posedge clk) begin
    if (rst)       ended <= 1'b1;
    else if (wrap) ended <= pre_end;
    else if (take) ended <= 1'b1;
  end

endmodule

// File: rtl/pte_notch_gen.sv
module pte_notch_gen #(
  parameter int unsigned NOTCH_CYC = 19,
  parameter int unsigned NW        = $clog2(NOTCH_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  output logic active
);

  logic [NW-1:0] rem;

  assign active = (rem != '0);

  // Start outranks the half-edge clear, so a notch may open at a half boundary.
  always_ff @(posedge clk) begin
    if (rst)              rem <= '0;
    else if (start)       rem <= NW'(NOTCH_CYC);
    else if (clear)       rem <= '0;
    else if (rem != '0)   rem <= rem - NW'(1);
  end

endmodule

// File: rtl/pte_drive_mux.sv
module pte_drive_mux (
  input  logic live,
  input  logic in_pos,
  input  logic notch,
  output logic pt_pos,
  output logic pt_neg
);

  always_comb begin
    pt_pos = live &&  in_pos && !notch;
    pt_neg = live && !in_pos && !notch;
  end

endmodule

// File: rtl/pte_gate_encoder.sv
module pte_gate_encoder
  import pte_pkg::*;
#(
  parameter int unsigned PERIOD_CLKS = 64,
  parameter int unsigned CLK_MHZ     = 125,
  parameter int unsigned NOTCH_NS    = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic ilim_trip,
  input  logic dmax_sel,
  output logic pt_pos,
  output logic pt_neg,
  output logic pwm_mon
);

  localparam int unsigned CW        = $clog2(PERIOD_CLKS);
  localparam int unsigned NOTCH_CYC = notch_len(CLK_MHZ, NOTCH_NS);
  localparam int unsigned NW        = $clog2(NOTCH_CYC + 1);

  logic live, wrap, half_edge, in_pos, on_win, pre_last, at_max_m1;
  logic trip_take, pre_end, notch_act;
  logic notch_start, notch_clear;

  pte_period_timer #(.PERIOD_CLKS(PERIOD_CLKS), .CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .dmax_sel  (dmax_sel),
    .live      (live),
    .wrap      (wrap),
    .half_edge (half_edge),
    .in_pos    (in_pos),
    .on_win    (on_win),
    .pre_last  (pre_last),
    .at_max_m1 (at_max_m1)
  );

  pte_ontime_ctrl u_ontime (
    .clk      (clk),
    .rst      (rst),
    .trip     (ilim_trip),
    .live     (live),
    .wrap     (wrap),
    .on_win   (on_win),
    .pre_last (pre_last),
    .pwm      (pwm_mon),
    .take     (trip_take),
    .pre_end  (pre_end)
  );

  assign notch_start = trip_take || pre_end;
  assign notch_clear = wrap || half_edge;

  pte_notch_gen #(.NOTCH_CYC(NOTCH_CYC), .NW(NW)) u_notch (
    .clk    (clk),
    .rst    (rst),
    .start  (notch_start),
    .clear  (notch_clear),
    .active (notch_act)
  );

  pte_drive_mux u_mux (
    .live   (live),
    .in_pos (in_pos),
    .notch  (notch_act),
    .pt_pos (pt_pos),
    .pt_neg (pt_neg)
  );

endmodule

// File: rtl/pte_gate_encoder_chk.sv
module pte_gate_encoder_chk (
  input logic clk,
  input logic rst,
  input logic pt_pos,
  input logic pt_neg,
  input logic pwm_mon,
  input logic live,
  input logic trip_take,
  input logic pre_end,
  input logic notch_act,
  input logic at_max_m1
);

  // R2
  drive_split_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !notch_act) |-> (pt_pos != pt_neg));

  // R5
  notch_low_chk: assert property (@(posedge clk) disable iff (rst)
    notch_act |-> (!pt_pos && !pt_neg));

  // R4
  trip_cut_chk: assert property (@(posedge clk) disable iff (rst)
    trip_take |=> (!pwm_mon && notch_act));

  // R3
  maxduty_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_mon && at_max_m1) |=> !pwm_mon);

  // R6
  no_notch_at_max_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_mon && at_max_m1) |=> !notch_act);

  // R7
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    pre_end |=> (!pwm_mon && notch_act));

endmodule

bind pte_gate_encoder pte_gate_encoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pt_pos    (pt_pos),
  .pt_neg    (pt_neg),
  .pwm_mon   (pwm_mon),
  .live      (live),
  .trip_take (trip_take),
  .pre_end   (pre_end),
  .notch_act (notch_act),
  .at_max_m1 (at_max_m1)
);

// File: tb/pte_gate_encoder_tb.sv
module pte_gate_encoder_tb;

  localparam int P   = 64;
  localparam int H   = P / 2;
  localparam int MHZ = 125;
  localparam int NS  = 150;
  // Round up: the smallest whole clock count covering NS.
  localparam int N   = (MHZ * NS) / 1000 + (((MHZ * NS) % 1000) != 0 ? 1 : 0);

  logic clk = 1'b0;
  logic rst, ilim_trip, dmax_sel;
  logic pt_pos, pt_neg, pwm_mon;

  int  checks = 0;
  int  errs   = 0;
  int  cyc    = 0;
  bit  done   = 1'b0;
  bit  prev_pre = 1'b0;

  always #4 clk = ~clk;

  pte_gate_encoder #(.PERIOD_CLKS(P), .CLK_MHZ(MHZ), .NOTCH_NS(NS)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .ilim_trip (ilim_trip),
    .dmax_sel  (dmax_sel),
    .pt_pos    (pt_pos),
    .pt_neg    (pt_neg),
    .pwm_mon   (pwm_mon)
  );

  task automatic cmp(input string req, input int t, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s cycle %0d count %0d: pt+/pt-/pwm got %b expected %b", req, cyc, t, act, exp);
    end
  endtask

  // One period: trip held over counts ts..te (ts < 0 means none), mode_now is the
  // limit latched at this period's start; mode_next is applied for the next one.
  task automatic run_period(input int ts, input int te, input bit mode_now, input bit mode_next);
    int lim, e, ns;
    bit has_notch;
    lim = mode_now ? (P * 3) / 4 : P / 2;
    if (prev_pre) begin
      e = 0; ns = 0; has_notch = 1'b1;                 // R7
    end else if (ts >= 0 && ts <= lim - 2) begin
      e = ts + 1; ns = ts + 1; has_notch = 1'b1;       // R4, first trip only
    end else begin
      e = lim; ns = 0; has_notch = 1'b0;               // R3, R6
    end
    for (int t = 0; t < P; t++) begin
      bit nt, xp, xn, xw;
      string tag;
      @(negedge clk);
      cyc++;
      // R5, R8: notch of N clocks, clipped at the end of its own half.
      nt = has_notch && t >= ns && t < ns + N && ((ns < H) ? (t < H) : 1'b1);
      xw = (t < e);
      xp = (t <  H) && !nt;
      xn = (t >= H) && !nt;
      if (pwm_mon !== xw)        tag = prev_pre ? "R7" : (has_notch ? "R4" : "R3");
      else if (!has_notch)       tag = "R6";
      else if (prev_pre)         tag = "R7";
      else if (ns >= H)          tag = "R8";
      else if (nt)               tag = "R5";
      else                       tag = "R2";
      cmp(tag, t, {pt_pos, pt_neg, pwm_mon}, {xp, xn, xw});
      ilim_trip = (ts >= 0 && t >= ts && t <= te);
      // R9: a mid-period flip of the select must not change this period.
      if (t == 5)  dmax_sel = ~mode_now;
      if (t == 40) dmax_sel = mode_next;
    end
    prev_pre = (ts >= 0 && ts <= P - 1 && te >= P - 1);
  endtask

  initial begin
    rst = 1'b1; ilim_trip = 1'b0; dmax_sel = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp("R1", 0, {pt_pos, pt_neg, pwm_mon}, 3'b000);
    end
    rst = 1'b0;
    #1;
    cmp("R1", 0, {pt_pos, pt_neg, pwm_mon}, 3'b000);

    // Single-clock trip at every count, plus a no-trip period, in each mode.
    for (int m = 0; m < 2; m++) begin
      for (int k = -1; k < P; k++) begin
        bit nx;
        nx = (m == 0 && k == P - 1) ? 1'b1 : m[0];
        run_period(k, k, m[0], nx);
      end
    end
    // Held trips: only the first is honoured; a hold into the last count chains 0% periods.
    run_period(3, 20, 1'b1, 1'b1);
    run_period(10, P - 1, 1'b1, 1'b0);
    run_period(0, P - 1, 1'b0, 1'b0);
    run_period(-1, -1, 1'b0, 1'b0);
    run_period(-1, -1, 1'b0, 1'b1);
    run_period(30, 45, 1'b1, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

endmodule